// File: doc/BRIEF.md
# Secure Boot Handshake Sequencer

This block runs on the host side of a secure boot exchange with a remote boot loader. The two sides talk through a pair of 32-bit mailbox words. The host posts a magic code in a host-status word. It then reads a device-status word again and again until the exact reply it expects shows up. Between the handshakes, the sequencer fills in the image header in the device's control area: a ring-reset word, a version word, the signature, the hash and the payload size. It then hands the payload transfer to a separate block-streaming engine. When authentication is accepted, it gives the device permission to jump.

All register traffic leaves through a single request/acknowledge bus master port, one access at a time. The header words come from the host's image buffer through a small index/word lookup port. Every wait on the device is bounded by a cycle limit. After a failure other than a bus fault, the sequencer reads the device's status and error words so that the reason for the failure is held on its outputs. Only the final acknowledgement accepts two replies, so that older boot ROMs that never report authentication still complete.

Top module: `hs_boot_seq`

## Requirements
- R1: After reset the block is idle: no bus request, and `done_ok`, `fail`, `timeout`, `err_valid` and `busy` are all low.
- R2: A `start` pulse while not busy runs the exchange. The host-status word (byte address 0x1000) receives exactly this sequence: 0x87654321, 0xA753BD99, 0xABCDDCBA, 0xD4C64A99, 0x174FC882. On success the block ends with `done_ok` high and `fail` low.
- R3: After the device reports ready (0x87654321) and before 0xABCDDCBA is posted, the block writes the following. 0xFFFFFFFF goes to the ring base 0x0000. 0x00000001 goes to 0x100C. Image words 0..15 go to 0x1040 + 4*k. Image words 16..17 go to 0x1080 + 4*j. `pay_len` goes to 0x1008.
- R4: While waiting for 0xBD53EF99, once it is seen, the block reads the device-info word at 0x110C and presents it on `dev_info`.
- R5: Each wait reads the device-status word (0x1004) repeatedly. Any value other than the exact expected code, including 0x12345678, keeps the block polling.
- R6: A wait that has not matched after `TIMEOUT_CYC` cycles fails the exchange with `timeout` high. A successful run never shows `timeout`.
- R7: After 0xD4C64A99 is posted, the block waits for 0xD4C64A99 from the device. If that wait times out, it waits again for 0x7AB41D19. Either reply leads to the jump code. If neither arrives, the run fails with `timeout`.
- R8: On a timeout, stream error or misaligned payload, the block reads the status-info word at 0x1100. If that word is 0x12345678, it ends failed with `err_valid` low. Otherwise it reads the error-info word at 0x1104 and holds its low byte on `err_code` with `err_valid` high. Known codes are 0x05, 0x0F, 0x10, 0x11 and 0x18.
- R9: An access acknowledged with `bus_err` ends the exchange at once with `fail` high and `timeout` low. No further bus request is made after it.
- R10: A `pay_len` that is not a multiple of `BLOCK_BYTES` fails the run without pulsing `stream_go`. A `stream_err` reported with `stream_done` also fails the run, and `timeout` stays low in both cases.
- R11: `bus_req` stays high with stable address, direction and write data until `bus_ack`. `stream_go` is a single-cycle pulse issued exactly once per successful run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin (or restart) the exchange |
| pay_len | input | 32 | Payload byte count, header excluded |
| img_idx | output | IDX_W | Index of the header word requested from the image buffer |
| img_word | input | 32 | Image header word at `img_idx` |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Byte address of the access |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access complete, one cycle |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| bus_err | input | 1 | Access failed, valid with `bus_ack` |
| stream_go | output | 1 | One-cycle start pulse to the streaming engine |
| stream_done | input | 1 | Streaming finished, one cycle |
| stream_err | input | 1 | Streaming failed, valid with `stream_done` |
| busy | output | 1 | Exchange in progress |
| done_ok | output | 1 | Exchange finished successfully |
| fail | output | 1 | Exchange failed |
| timeout | output | 1 | A device wait expired |
| err_code | output | 8 | Captured device error code |
| err_valid | output | 1 | `err_code` holds a captured value |
| dev_info | output | 32 | Device information word read during the exchange |

## Verification
The checks assume that the responder returns `bus_ack` for one cycle only, and only while `bus_req` is high. They also assume that `stream_done` arrives only after a `stream_go` pulse. The bench's device model acknowledges every request exactly one cycle after it sees it and drops the acknowledge the cycle after. Its streaming model answers a fixed number of cycles after each start pulse. Polling delays, missing replies, injected bus faults and stream errors are all produced inside that same timing discipline, so the bus and pulse properties are exercised without the stimulus ever breaking them.

// File: rtl/hs_pkg.sv
package hs_pkg;

    localparam int DATA_W = 32;

    // host-status codes
    localparam logic [31:0] H_READY     = 32'h8765_4321;
    localparam logic [31:0] H_INFO_READ = 32'hA753_BD99;
    localparam logic [31:0] H_UP_PEND   = 32'hABCD_DCBA;
    localparam logic [31:0] H_UP_DONE   = 32'hD4C6_4A99;
    localparam logic [31:0] H_JUMP      = 32'h174F_C882;

    // device-status codes
    localparam logic [31:0] D_NOT_READY  = 32'h1234_5678;
    localparam logic [31:0] D_READY      = 32'h8765_4321;
    localparam logic [31:0] D_INFO_READY = 32'hBD53_EF99;
    localparam logic [31:0] D_DL_PEND    = 32'hABCD_DCBA;
    localparam logic [31:0] D_DL_DONE    = 32'hCAFE_FECA;
    localparam logic [31:0] D_AUTH_OK    = 32'hD4C6_4A99;
    localparam logic [31:0] D_AUTH_FAIL  = 32'h174F_C882;
    localparam logic [31:0] D_PUBKEY_RDY = 32'h7AB4_1D19;

    localparam logic [31:0] STAT_CLEAN   = 32'h1234_5678;

    // device address map (bytes)
    localparam logic [31:0] A_RING      = 32'h0000_0000;
    localparam logic [31:0] A_HOST_ST   = 32'h0000_1000;
    localparam logic [31:0] A_DEV_ST    = 32'h0000_1004;
    localparam logic [31:0] A_IMG_SIZE  = 32'h0000_1008;
    localparam logic [31:0] A_VERSION   = 32'h0000_100C;
    localparam logic [31:0] A_SIG       = 32'h0000_1040;
    localparam logic [31:0] A_HASH      = 32'h0000_1080;
    localparam logic [31:0] A_STAT_INFO = 32'h0000_1100;
    localparam logic [31:0] A_ERR_INFO  = 32'h0000_1104;
    localparam logic [31:0] A_DEV_INFO  = 32'h0000_110C;

    localparam logic [31:0] VERSION_WORD = 32'h0000_0001;

    typedef enum logic [4:0] {
        S_IDLE,
        S_WR_READY,
        S_WAIT_INFO,
        S_RD_INFO,
        S_WR_INFOREAD,
        S_WAIT_READY,
        S_WR_RING,
        S_WR_VER,
        S_WR_SIG,
        S_WR_HASH,
        S_WR_SIZE,
        S_WR_PEND,
        S_WAIT_PEND,
        S_STREAM_GO,
        S_STREAM_WAIT,
        S_WR_UPDONE,
        S_WAIT_AUTH,
        S_WAIT_PUBKEY,
        S_WR_JUMP,
        S_DIAG_STAT,
        S_DIAG_ERR,
        S_OK,
        S_FAIL
    } seq_st_e;

    typedef struct packed {
        seq_st_e     state;
        logic [7:0]  idx;
        logic        timeout;
        logic        err_valid;
        logic [7:0]  err_code;
        logic [31:0] info;
        logic        go;
    } seq_t;

    typedef struct packed {
        logic        req;
        logic        we;
        logic [31:0] addr;
        logic [31:0] wdata;
    } bus_t;

endpackage

// File: rtl/hs_bus_port.sv
module hs_bus_port
    import hs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic        cmd_we,
    input  logic [31:0] cmd_addr,
    input  logic [31:0] cmd_wdata,
    output logic        cmd_done,
    output logic        cmd_err,
    output logic [31:0] cmd_rdata,
    output logic        bus_req,
    output logic        bus_we,
    output logic [31:0] bus_addr,
    output logic [31:0] bus_wdata,
    input  logic        bus_ack,
    input  logic        bus_err,
    input  logic [31:0] bus_rdata
);

    bus_t bus_d, bus_q;

    always_comb begin
        bus_d = bus_q;
        if (bus_q.req) begin
            if (bus_ack) bus_d.req = 1'b0;
        end else if (cmd_valid) begin
            bus_d.req   = 1'b1;
            bus_d.we    = cmd_we;
            bus_d.addr  = cmd_addr;
            bus_d.wdata = cmd_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bus_q <= '0;
        else        bus_q <= bus_d;
    end

    assign cmd_done  = bus_q.req & bus_ack;
    assign cmd_err   = bus_err;
    assign cmd_rdata = bus_rdata;
    assign bus_req   = bus_q.req;
    assign bus_we    = bus_q.we;
    assign bus_addr  = bus_q.addr;
    assign bus_wdata = bus_q.wdata;

endmodule

// File: rtl/hs_wait_timer.sv
module hs_wait_timer #(
    parameter int LIMIT = 5_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic expired
);

    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr)              cnt_d = '0;
        else if (cnt_q == LIM) cnt_d = cnt_q;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == LIM);

endmodule

// File: rtl/hs_seq_ctrl.sv
module hs_seq_ctrl
    import hs_pkg::*;
#(
    parameter int BLOCK_BYTES = 1024,
    parameter int SIG_WORDS   = 16,
    parameter int HASH_WORDS  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] pay_len,
    input  logic [31:0] img_word,
    input  logic        cmd_done,
    input  logic        cmd_err,
    input  logic [31:0] cmd_rdata,
    input  logic        tmr_expired,
    input  logic        stream_done,
    input  logic        stream_err,
    output logic        cmd_valid,
    output logic        cmd_we,
    output logic [31:0] cmd_addr,
    output logic [31:0] cmd_wdata,
    output logic        tmr_clr,
    output seq_t        seq
);

    localparam int BLK_LSB = $clog2(BLOCK_BYTES);
    localparam logic [7:0] SIG_LAST  = 8'(SIG_WORDS - 1);
    localparam logic [7:0] HASH_LAST = 8'(SIG_WORDS + HASH_WORDS - 1);

    seq_t    seq_d, seq_q;
    logic    rd_ok;
    logic    wr_st, wait_st;
    seq_st_e nxt_wr, nxt_ok, nxt_to;
    logic [31:0] exp_code;
    logic    len_bad;

    assign rd_ok   = cmd_done & ~cmd_err;
    assign len_bad = (pay_len[BLK_LSB-1:0] != '0);

    always_comb begin
        seq_d     = seq_q;
        seq_d.go  = 1'b0;
        cmd_valid = 1'b0;
        cmd_we    = 1'b0;
        cmd_addr  = '0;
        cmd_wdata = '0;
        wr_st     = 1'b0;
        wait_st   = 1'b0;
        nxt_wr    = seq_q.state;
        nxt_ok    = seq_q.state;
        nxt_to    = S_DIAG_STAT;
        exp_code  = '0;

        unique case (seq_q.state)
            S_IDLE, S_OK, S_FAIL: begin
                if (start) begin
                    seq_d.state     = S_WR_READY;
                    seq_d.idx       = '0;
                    seq_d.timeout   = 1'b0;
                    seq_d.err_valid = 1'b0;
                    seq_d.err_code  = '0;
                end
            end
            S_WR_READY: begin
                wr_st = 1'b1; cmd_addr = A_HOST_ST; cmd_wdata = H_READY;
                nxt_wr = S_WAIT_INFO;
            end
            S_WAIT_INFO: begin
                wait_st = 1'b1; exp_code = D_INFO_READY; nxt_ok = S_RD_INFO;
            end
            S_RD_INFO: begin
                cmd_valid = 1'b1; cmd_addr = A_DEV_INFO;
                if (rd_ok) begin
                    seq_d.info  = cmd_rdata;
                    seq_d.state = S_WR_INFOREAD;
                end
            end
            S_WR_INFOREAD: begin
                wr_st = 1'b1; cmd_addr = A_HOST_ST; cmd_wdata = H_INFO_READ;
                nxt_wr = S_WAIT_READY;
            end
            S_WAIT_READY: begin
                wait_st = 1'b1; exp_code = D_READY; nxt_ok = S_WR_RING;
            end
            S_WR_RING: begin
                wr_st = 1'b1; cmd_addr = A_RING; cmd_wdata = '1;
                nxt_wr = S_WR_VER;
            end
            S_WR_VER: begin
                wr_st = 1'b1; cmd_addr = A_VERSION; cmd_wdata = VERSION_WORD;
                nxt_wr = S_WR_SIG;
            end
            S_WR_SIG: begin
                cmd_valid = 1'b1; cmd_we = 1'b1;
                cmd_addr  = A_SIG + (32'(seq_q.idx) << 2);
                cmd_wdata = img_word;
                if (rd_ok) begin
                    seq_d.idx = seq_q.idx + 8'd1;
                    if (seq_q.idx == SIG_LAST) seq_d.state = S_WR_HASH;
                end
            end
            S_WR_HASH: begin
                cmd_valid = 1'b1; cmd_we = 1'b1;
                cmd_addr  = A_HASH + ((32'(seq_q.idx) - 32'(SIG_WORDS)) << 2);
                cmd_wdata = img_word;
                if (rd_ok) begin
                    seq_d.idx = seq_q.idx + 8'd1;
                    if (seq_q.idx == HASH_LAST) seq_d.state = S_WR_SIZE;
                end
            end
            S_WR_SIZE: begin
                wr_st = 1'b1; cmd_addr = A_IMG_SIZE; cmd_wdata = pay_len;
                nxt_wr = S_WR_PEND;
            end
            S_WR_PEND: begin
                wr_st = 1'b1; cmd_addr = A_HOST_ST; cmd_wdata = H_UP_PEND;
                nxt_wr = S_WAIT_PEND;
            end
            S_WAIT_PEND: begin
                wait_st = 1'b1; exp_code = D_DL_PEND; nxt_ok = S_STREAM_GO;
            end
            S_STREAM_GO: begin
                if (len_bad) begin
                    seq_d.state = S_DIAG_STAT;
                end else begin
                    seq_d.go    = 1'b1;
                    seq_d.state = S_STREAM_WAIT;
                end
            end
            S_STREAM_WAIT: begin
                if (stream_done) seq_d.state = stream_err ? S_DIAG_STAT : S_WR_UPDONE;
            end
            S_WR_UPDONE: begin
                wr_st = 1'b1; cmd_addr = A_HOST_ST; cmd_wdata = H_UP_DONE;
                nxt_wr = S_WAIT_AUTH;
            end
            S_WAIT_AUTH: begin
                wait_st = 1'b1; exp_code = D_AUTH_OK; nxt_ok = S_WR_JUMP;
                nxt_to  = S_WAIT_PUBKEY;
            end
            S_WAIT_PUBKEY: begin
                wait_st = 1'b1; exp_code = D_PUBKEY_RDY; nxt_ok = S_WR_JUMP;
            end
            S_WR_JUMP: begin
                wr_st = 1'b1; cmd_addr = A_HOST_ST; cmd_wdata = H_JUMP;
                nxt_wr = S_OK;
            end
            S_DIAG_STAT: begin
                cmd_valid = 1'b1; cmd_addr = A_STAT_INFO;
                if (rd_ok) seq_d.state = (cmd_rdata == STAT_CLEAN) ? S_FAIL : S_DIAG_ERR;
            end
            S_DIAG_ERR: begin
                cmd_valid = 1'b1; cmd_addr = A_ERR_INFO;
                if (rd_ok) begin
                    seq_d.err_code  = cmd_rdata[7:0];
                    seq_d.err_valid = 1'b1;
                    seq_d.state     = S_FAIL;
                end
            end
            default: seq_d.state = S_IDLE;
        endcase

        if (wr_st) begin
            cmd_valid = 1'b1;
            cmd_we    = 1'b1;
            if (rd_ok) seq_d.state = nxt_wr;
        end

        if (wait_st) begin
            cmd_valid = 1'b1;
            cmd_addr  = A_DEV_ST;
            if (rd_ok) begin
                if (cmd_rdata == exp_code) begin
                    seq_d.state = nxt_ok;
                end else if (tmr_expired) begin
                    seq_d.state = nxt_to;
                    if (nxt_to == S_DIAG_STAT) seq_d.timeout = 1'b1;
                end
            end
        end

        // a faulty access ends the run with no diagnostics
        if (cmd_valid && cmd_done && cmd_err) seq_d.state = S_FAIL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '{state: S_IDLE, default: '0};
        else        seq_q <= seq_d;
    end

    assign tmr_clr = (seq_d.state != seq_q.state);
    assign seq     = seq_q;

endmodule

// File: rtl/hs_boot_seq.sv
module hs_boot_seq
    import hs_pkg::*;
#(
    parameter int TIMEOUT_CYC = 5_000_000,
    parameter int BLOCK_BYTES = 1024,
    parameter int SIG_WORDS   = 16,
    parameter int HASH_WORDS  = 2,
    localparam int IDX_W      = $clog2(SIG_WORDS + HASH_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [31:0]      pay_len,
    output logic [IDX_W-1:0] img_idx,
    input  logic [31:0]      img_word,
    output logic             bus_req,
    output logic             bus_we,
    output logic [31:0]      bus_addr,
    output logic [31:0]      bus_wdata,
    input  logic             bus_ack,
    input  logic [31:0]      bus_rdata,
    input  logic             bus_err,
    output logic             stream_go,
    input  logic             stream_done,
    input  logic             stream_err,
    output logic             busy,
    output logic             done_ok,
    output logic             fail,
    output logic             timeout,
    output logic [7:0]       err_code,
    output logic             err_valid,
    output logic [31:0]      dev_info
);

    logic        cmd_valid, cmd_we, cmd_done, cmd_err;
    logic [31:0] cmd_addr, cmd_wdata, cmd_rdata;
    logic        tmr_clr, tmr_expired;
    seq_t        seq;

    hs_bus_port u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_we    (cmd_we),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .cmd_done  (cmd_done),
        .cmd_err   (cmd_err),
        .cmd_rdata (cmd_rdata),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_ack   (bus_ack),
        .bus_err   (bus_err),
        .bus_rdata (bus_rdata)
    );

    hs_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .expired (tmr_expired)
    );

    hs_seq_ctrl #(
        .BLOCK_BYTES (BLOCK_BYTES),
        .SIG_WORDS   (SIG_WORDS),
        .HASH_WORDS  (HASH_WORDS)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .pay_len     (pay_len),
        .img_word    (img_word),
        .cmd_done    (cmd_done),
        .cmd_err     (cmd_err),
        .cmd_rdata   (cmd_rdata),
        .tmr_expired (tmr_expired),
        .stream_done (stream_done),
        .stream_err  (stream_err),
        .cmd_valid   (cmd_valid),
        .cmd_we      (cmd_we),
        .cmd_addr    (cmd_addr),
        .cmd_wdata   (cmd_wdata),
        .tmr_clr     (tmr_clr),
        .seq         (seq)
    );

    assign img_idx   = seq.idx[IDX_W-1:0];
    assign stream_go = seq.go;
    assign done_ok   = (seq.state == S_OK);
    assign fail      = (seq.state == S_FAIL);
    assign busy      = !(seq.state inside {S_IDLE, S_OK, S_FAIL});
    assign timeout   = seq.timeout;
    assign err_code  = seq.err_code;
    assign err_valid = seq.err_valid;
    assign dev_info  = seq.info;

endmodule

module hs_boot_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_req,
    input logic        bus_ack,
    input logic        bus_we,
    input logic [31:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic        stream_go,
    input logic        done_ok,
    input logic        fail,
    input logic        timeout,
    input logic        err_valid
);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

    // R11
    go_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stream_go |=> !stream_go);

    // R2
    end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_ok && fail));

    // R9
    quiet_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ok || fail) |-> !bus_req && !stream_go);

    // R8
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> fail);

    // R6
    ok_no_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_ok |-> !timeout);

endmodule

bind hs_boot_seq hs_boot_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_ack   (bus_ack),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .stream_go (stream_go),
    .done_ok   (done_ok),
    .fail      (fail),
    .timeout   (timeout),
    .err_valid (err_valid)
);

// File: tb/hs_boot_seq_test.sv
module hs_boot_seq_test;
    import hs_pkg::*;

    localparam int TO  = 200;
    localparam int IDW = $clog2(18);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [31:0] pay_len = 32'h3000;
    logic [IDW-1:0] img_idx;
    logic [31:0] img_word;
    logic bus_req, bus_we, bus_ack, bus_err;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic stream_go, stream_done, stream_err;
    logic busy, done_ok, fail, timeout, err_valid;
    logic [7:0] err_code;
    logic [31:0] dev_info;

    always #5 clk = ~clk;

    assign img_word = 32'h5EC0_0000 + 32'(img_idx);

    hs_boot_seq #(.TIMEOUT_CYC(TO)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .pay_len(pay_len),
        .img_idx(img_idx), .img_word(img_word),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .stream_go(stream_go), .stream_done(stream_done), .stream_err(stream_err),
        .busy(busy), .done_ok(done_ok), .fail(fail), .timeout(timeout),
        .err_code(err_code), .err_valid(err_valid), .dev_info(dev_info)
    );

    // scenario knobs
    int poll_delay = 0;
    int auth_mode  = 0;   // 0 auth-ok, 1 legacy key-ready, 2 no good reply
    bit hang_info  = 0;
    int err_wr_at  = 0;   // write number that gets a bus fault, 0 none
    bit serr_mode  = 0;
    logic [31:0] stat_val = STAT_CLEAN;
    logic [31:0] err_val  = 32'h0;

    // device model state and logs
    logic [31:0] dev_st;
    int poll_left, wr_cnt, hcnt, go_cnt, sdelay;
    logic [31:0] hlog [0:15];
    logic [31:0] sig_log [0:15];
    logic [31:0] hash_log [0:1];
    logic [31:0] ring_val, ver_val, size_val;

    always @(posedge clk) begin
        if (!rst_n) begin
            bus_ack <= 1'b0; bus_err <= 1'b0; bus_rdata <= '0;
            dev_st <= D_NOT_READY; poll_left <= 0; wr_cnt <= 0; hcnt <= 0;
            ring_val <= '0; ver_val <= '0; size_val <= '0;
        end else begin
            bus_ack <= 1'b0; bus_err <= 1'b0;
            if (bus_req && !bus_ack) begin
                bus_ack <= 1'b1;
                if (bus_we) begin
                    wr_cnt <= wr_cnt + 1;
                    if (wr_cnt + 1 == err_wr_at) begin
                        bus_err <= 1'b1;
                    end else begin
                        if (bus_addr == A_HOST_ST) begin
                            hlog[hcnt] <= bus_wdata;
                            hcnt <= hcnt + 1;
                            poll_left <= poll_delay;
                            case (bus_wdata)
                                H_READY:     if (!hang_info) dev_st <= D_INFO_READY;
                                H_INFO_READ: dev_st <= D_READY;
                                H_UP_PEND:   dev_st <= D_DL_PEND;
                                H_UP_DONE:   dev_st <= (auth_mode == 0) ? D_AUTH_OK :
                                                       (auth_mode == 1) ? D_PUBKEY_RDY : D_AUTH_FAIL;
                                default: ;
                            endcase
                        end
                        if (bus_addr == A_RING)     ring_val <= bus_wdata;
                        if (bus_addr == A_VERSION)  ver_val  <= bus_wdata;
                        if (bus_addr == A_IMG_SIZE) size_val <= bus_wdata;
                        if (bus_addr >= A_SIG && bus_addr < A_SIG + 64)
                            sig_log[(bus_addr - A_SIG) >> 2] <= bus_wdata;
                        if (bus_addr >= A_HASH && bus_addr < A_HASH + 8)
                            hash_log[(bus_addr - A_HASH) >> 2] <= bus_wdata;
                    end
                end else begin
                    case (bus_addr)
                        A_DEV_ST: begin
                            if (poll_left > 0) begin
                                bus_rdata <= D_NOT_READY;
                                poll_left <= poll_left - 1;
                            end else bus_rdata <= dev_st;
                        end
                        A_STAT_INFO: bus_rdata <= stat_val;
                        A_ERR_INFO:  bus_rdata <= err_val;
                        A_DEV_INFO:  bus_rdata <= 32'h0000_2A90;
                        default:     bus_rdata <= '0;
                    endcase
                end
            end
        end
    end

    // streaming engine model
    always @(posedge clk) begin
        if (!rst_n) begin
            go_cnt <= 0; sdelay <= 0; stream_done <= 1'b0; stream_err <= 1'b0;
        end else begin
            stream_done <= 1'b0; stream_err <= 1'b0;
            if (stream_go) begin
                go_cnt <= go_cnt + 1; sdelay <= 4;
            end else if (sdelay > 1) begin
                sdelay <= sdelay - 1;
            end else if (sdelay == 1) begin
                sdelay <= 0; stream_done <= 1'b1; stream_err <= serr_mode;
            end
        end
    end

    // bus protocol and quiet-end monitors, sampled away from the edge
    int viol, post_req;
    logic p_req, p_ack, p_we;
    logic [31:0] p_addr, p_wdata;
    always @(negedge clk) begin
        if (!rst_n) begin
            viol = 0; post_req = 0; p_req = 0; p_ack = 0;
        end else begin
            if (p_req && !p_ack && (!bus_req || bus_addr != p_addr || bus_we != p_we || bus_wdata != p_wdata))
                viol++;
            if ((done_ok || fail) && bus_req) post_req++;
            p_req = bus_req; p_ack = bus_ack; p_we = bus_we; p_addr = bus_addr; p_wdata = bus_wdata;
        end
    end

    int checks = 0, failures = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic run_to_end();
        int n;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        n = 0;
        while (!(done_ok || fail) && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(n < 5000, "R2 run ended", 32'(n), 32'd5000);
    endtask

    task automatic setup(input int pd, input int am, input bit hi, input int ew,
                         input bit se, input logic [31:0] sv, input logic [31:0] ev,
                         input logic [31:0] len);
        poll_delay = pd; auth_mode = am; hang_info = hi; err_wr_at = ew;
        serr_mode = se; stat_val = sv; err_val = ev; pay_len = len;
        do_reset();
    endtask

    task automatic t_reset();
        setup(0, 0, 0, 0, 0, STAT_CLEAN, 0, 32'h3000);
        chk(!bus_req && !done_ok && !fail && !timeout && !err_valid && !busy,
            "R1 idle after reset",
            {26'b0, bus_req, done_ok, fail, timeout, err_valid, busy}, 32'h0);
    endtask

    task automatic t_normal();
        logic [31:0] exp_h [0:4];
        exp_h = '{H_READY, H_INFO_READ, H_UP_PEND, H_UP_DONE, H_JUMP};
        setup(3, 0, 0, 0, 0, STAT_CLEAN, 0, 32'h3000);
        run_to_end();
        chk(done_ok && !fail, "R2 done_ok", {30'b0, done_ok, fail}, 32'h2);
        chk(hcnt == 5, "R2 host code count", 32'(hcnt), 32'd5);
        for (int i = 0; i < 5; i++)
            chk(hlog[i] == exp_h[i], "R2 host code order", hlog[i], exp_h[i]);
        chk(ring_val == 32'hFFFF_FFFF, "R3 ring init", ring_val, 32'hFFFF_FFFF);
        chk(ver_val == 32'h1, "R3 version", ver_val, 32'h1);
        for (int i = 0; i < 16; i++)
            chk(sig_log[i] == 32'h5EC0_0000 + 32'(i), "R3 signature word", sig_log[i], 32'h5EC0_0000 + 32'(i));
        for (int j = 0; j < 2; j++)
            chk(hash_log[j] == 32'h5EC0_0010 + 32'(j), "R3 hash word", hash_log[j], 32'h5EC0_0010 + 32'(j));
        chk(size_val == 32'h3000, "R3 size word", size_val, 32'h3000);
        chk(dev_info == 32'h0000_2A90, "R4 device info", dev_info, 32'h0000_2A90);
        chk(!timeout, "R5 polling through not-ready replies", {31'b0, timeout}, 32'h0);
        chk(go_cnt == 1, "R11 single stream start", 32'(go_cnt), 32'd1);
        chk(viol == 0, "R11 request held until ack", 32'(viol), 32'd0);
    endtask

    task automatic t_legacy();
        setup(2, 1, 0, 0, 0, STAT_CLEAN, 0, 32'h0400);
        run_to_end();
        chk(done_ok && !timeout, "R7 legacy key-ready accepted", {30'b0, done_ok, timeout}, 32'h2);
        chk(hcnt == 5 && hlog[4] == H_JUMP, "R7 jump after legacy reply", hlog[4], H_JUMP);
    endtask

    task automatic t_no_auth();
        setup(0, 2, 0, 0, 0, STAT_CLEAN, 32'h11, 32'h0800);
        run_to_end();
        chk(fail && timeout, "R7 no auth reply fails with timeout", {30'b0, fail, timeout}, 32'h3);
        chk(hcnt == 4, "R7 no jump code", 32'(hcnt), 32'd4);
        chk(!err_valid, "R8 clean status skips error capture", {31'b0, err_valid}, 32'h0);
    endtask

    task automatic t_hang();
        setup(0, 0, 1, 0, 0, 32'h0000_0001, 32'h0000_000F, 32'h3000);
        run_to_end();
        chk(fail && timeout, "R6 info wait expires", {30'b0, fail, timeout}, 32'h3);
        chk(hcnt == 1, "R6 stops after first code", 32'(hcnt), 32'd1);
        chk(err_valid && err_code == 8'h0F, "R8 error code captured", {23'b0, err_valid, err_code}, 32'h10F);
    endtask

    task automatic t_bus_err();
        setup(0, 0, 0, 3, 0, 32'h2, 32'h5, 32'h3000);
        run_to_end();
        chk(fail && !timeout && !err_valid, "R9 bus fault aborts",
            {29'b0, fail, timeout, err_valid}, 32'h4);
        repeat (50) @(negedge clk);
        chk(post_req == 0, "R9 no request after fault", 32'(post_req), 32'd0);
        chk(hcnt == 2, "R9 host codes before fault", 32'(hcnt), 32'd2);
    endtask

    task automatic t_stream_err();
        setup(1, 0, 0, 0, 1, 32'h2, 32'h18, 32'h3000);
        run_to_end();
        chk(fail && !timeout, "R10 stream error fails", {30'b0, fail, timeout}, 32'h2);
        chk(err_valid && err_code == 8'h18, "R8 stream error code", {23'b0, err_valid, err_code}, 32'h118);
        chk(go_cnt == 1, "R10 stream started once", 32'(go_cnt), 32'd1);
    endtask

    task automatic t_misaligned();
        setup(0, 0, 0, 0, 0, STAT_CLEAN, 0, 32'h1001);
        run_to_end();
        chk(fail && !timeout, "R10 misaligned length fails", {30'b0, fail, timeout}, 32'h2);
        chk(go_cnt == 0, "R10 no stream start", 32'(go_cnt), 32'd0);
        chk(hcnt == 3, "R10 stops after upload-pending", 32'(hcnt), 32'd3);
    endtask

    initial begin
        t_reset();
        t_normal();
        t_legacy();
        t_no_auth();
        t_hang();
        t_bus_err();
        t_stream_err();
        t_misaligned();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd150000, 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule